// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt request lines from several peripheral sources and presents a single request, together with the index of the chosen source, to a processor. Each source has a fixed numeric priority, set by a parameter. The background program runs at level 0, so any source with a priority above 0 can interrupt it. The default build has three sources. Source 0 has priority 2, source 1 has priority 4 and source 2 has priority 5. These might be a printer, a disk and a communications line.

A mode input is read every cycle and chooses between two service disciplines. In one-at-a-time mode, no request is presented while any handler is active. Requests that arrive in that time stay pending and are offered in priority order once the handler finishes. In preemptive mode, a pending source whose priority is above the running level is presented while a handler runs. Accepting it pushes the running level onto a small stack. An end-of-handler pulse pops the stack and restores the interrupted level. The processor accepts a presented request with an acknowledge pulse and reports completion with an end-of-handler pulse. Vector tables and the processor are outside the block.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, `intReq` and `errFlag` are low, no source is pending, the running level is 0 and no handler is active.
- R2: A source becomes pending only on a 0-to-1 transition of its `irqIn` bit. A line held high after its request is acknowledged does not raise a second request.
- R3: Among the eligible pending sources, `intVec` names the one with the highest priority. Equal priorities go to the lowest source index. The default priorities are source 0 = 2, source 1 = 4 and source 2 = 5.
- R4: With `nestMode` = 0, `intReq` stays low while a handler is active. Pending sources are kept and are presented after the handler ends.
- R5: With `nestMode` = 1, a pending source whose priority is strictly above the running level is presented, even while a handler is active.
- R6: A pending source whose priority is at or below the running level is not presented until the running level falls below its priority.
- R7: An `ackIn` pulse while `intReq` is high clears the pending bit of the presented source, saves the running level, raises the running level to that source's priority and adds one active handler.
- R8: An `eohIn` pulse while a handler is active restores the saved level that was most recently pushed and removes one active handler.
- R9: When `STACK_DEPTH` handlers are active, no request is presented until one of them ends.
- R10: An `ackIn` pulse while `intReq` is low, or an `eohIn` pulse while no handler is active, drives `errFlag` high in that same cycle and leaves the state unchanged.
- R11: If `ackIn` and `eohIn` are high in the same cycle, the end-of-handler takes effect, the acknowledge is discarded and `errFlag` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_SRC | Request lines, one bit per source |
| ackIn | input | 1 | Processor accepts the presented request |
| eohIn | input | 1 | Processor finished the current handler |
| nestMode | input | 1 | 1 selects preemptive service, 0 selects one-at-a-time service |
| intReq | output | 1 | Request to the processor |
| intVec | output | $clog2(NUM_SRC) | Index of the presented source |
| errFlag | output | 1 | High in a cycle that has an acknowledge or end pulse that is not valid |

## Verification
A running level or stack entry that is wrong has no effect at the ports until it matters. The fault shows on the cycle after the pop that restores the bad level, as a request that appears too early or is held back wrongly. A wrong depth count shows as a missing error flag on a surplus end pulse, or as a request that leaks through in one-at-a-time mode. A pending bit that is lost or doubled shows as a missing or repeated vector within a few cycles of the next handler end. For these reasons the bench compares all three outputs in every cycle and runs long nested sequences, so that saved levels are exposed again and again.

// File: rtl/nic_pkg.sv
package nic_pkg;
  // Strobes from control to datapath for one clock cycle
  typedef struct packed {
    logic push;     // take the presented source into service
    logic pop;      // end the innermost handler
    logic flagErr;  // invalid ack or end pulse this cycle
  } nicStrobe_t;
endpackage

// File: rtl/nic_datapath.sv
module nic_datapath
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int PRIO_W = 3,
  parameter int STACK_DEPTH = 3,
  parameter logic [NUM_SRC*PRIO_W-1:0] SRC_PRIO = {3'd5, 3'd4, 3'd2},
  localparam int IDW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int DW = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  nicStrobe_t         strobe,
  input  logic [IDW-1:0]     selSrc,
  output logic [NUM_SRC-1:0] pendingQ,
  output logic [PRIO_W-1:0]  levelQ,
  output logic [DW-1:0]      depthQ
);
  logic [NUM_SRC-1:0] prevIrqQ;
  logic [NUM_SRC-1:0] riseVec;
  logic [NUM_SRC-1:0] clrVec;
  logic [PRIO_W-1:0]  stackQ [STACK_DEPTH];
  logic [PRIO_W-1:0]  topLevel;
  logic [PRIO_W-1:0]  selPrio;

  assign riseVec = irqIn & ~prevIrqQ;
  assign selPrio = SRC_PRIO[selSrc*PRIO_W +: PRIO_W];

  always_comb begin
    clrVec = '0;
    if (strobe.push) clrVec[selSrc] = 1'b1;
  end

  // Saved level that sits on top of the stack
  always_comb begin
    topLevel = '0;
    for (int e = 0; e < STACK_DEPTH; e++)
      if (depthQ == DW'(e + 1)) topLevel = stackQ[e];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIrqQ <= '0;
      pendingQ <= '0;
    end else begin
      prevIrqQ <= irqIn;
      pendingQ <= (pendingQ & ~clrVec) | riseVec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= '0;
      depthQ <= '0;
    end else if (strobe.pop) begin
      levelQ <= topLevel;
      depthQ <= depthQ - DW'(1);
    end else if (strobe.push) begin
      levelQ <= selPrio;
      depthQ <= depthQ + DW'(1);
    end
  end

  for (genvar e = 0; e < STACK_DEPTH; e++) begin : gStack
    always_ff @(posedge clk) begin
      if (!rstN) stackQ[e] <= '0;
      else if (strobe.push && !strobe.pop && depthQ == DW'(e)) stackQ[e] <= levelQ;
    end
  end
endmodule

// File: rtl/nic_control.sv
module nic_control
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int PRIO_W = 3,
  parameter int STACK_DEPTH = 3,
  parameter logic [NUM_SRC*PRIO_W-1:0] SRC_PRIO = {3'd5, 3'd4, 3'd2},
  localparam int IDW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int DW = $clog2(STACK_DEPTH + 1)
) (
  input  logic [NUM_SRC-1:0] pendingQ,
  input  logic [PRIO_W-1:0]  levelQ,
  input  logic [DW-1:0]      depthQ,
  input  logic               ackIn,
  input  logic               eohIn,
  input  logic               nestMode,
  output logic               intReq,
  output logic [IDW-1:0]     intVec,
  output nicStrobe_t         strobe
);
  logic [NUM_SRC-1:0] eligible;
  logic               stackFull;
  logic               noHandler;
  logic               anyWin;
  logic [PRIO_W-1:0]  bestPrio;

  assign stackFull = (depthQ == DW'(STACK_DEPTH));
  assign noHandler = (depthQ == '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : gElig
    assign eligible[g] = pendingQ[g] && !stackFull &&
                         (SRC_PRIO[g*PRIO_W +: PRIO_W] > levelQ) &&
                         (nestMode || noHandler);
  end

  // Highest priority wins; a strict compare keeps the lowest index on ties
  always_comb begin
    anyWin = 1'b0;
    bestPrio = '0;
    intVec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!anyWin || SRC_PRIO[i*PRIO_W +: PRIO_W] > bestPrio)) begin
        anyWin = 1'b1;
        bestPrio = SRC_PRIO[i*PRIO_W +: PRIO_W];
        intVec = IDW'(i);
      end
    end
  end

  assign intReq = anyWin;

  always_comb begin
    strobe.pop = eohIn && !noHandler;
    strobe.push = ackIn && intReq && !eohIn;
    strobe.flagErr = (ackIn && (!intReq || eohIn)) || (eohIn && noHandler);
  end
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int PRIO_W = 3,
  parameter int STACK_DEPTH = 3,
  parameter logic [NUM_SRC*PRIO_W-1:0] SRC_PRIO = {3'd5, 3'd4, 3'd2},
  localparam int IDW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int DW = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               ackIn,
  input  logic               eohIn,
  input  logic               nestMode,
  output logic               intReq,
  output logic [IDW-1:0]     intVec,
  output logic               errFlag
);
  nicStrobe_t         strobe;
  logic [NUM_SRC-1:0] pendingQ;
  logic [PRIO_W-1:0]  levelQ;
  logic [DW-1:0]      depthQ;

  nic_datapath #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .STACK_DEPTH(STACK_DEPTH), .SRC_PRIO(SRC_PRIO)
  ) uPath (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strobe(strobe), .selSrc(intVec),
    .pendingQ(pendingQ), .levelQ(levelQ), .depthQ(depthQ)
  );

  nic_control #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .STACK_DEPTH(STACK_DEPTH), .SRC_PRIO(SRC_PRIO)
  ) uCtrl (
    .pendingQ(pendingQ), .levelQ(levelQ), .depthQ(depthQ),
    .ackIn(ackIn), .eohIn(eohIn), .nestMode(nestMode),
    .intReq(intReq), .intVec(intVec), .strobe(strobe)
  );

  assign errFlag = strobe.flagErr;
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int NUM_SRC = 3,
  parameter int PRIO_W = 3,
  parameter int STACK_DEPTH = 3,
  parameter logic [NUM_SRC*PRIO_W-1:0] SRC_PRIO = {3'd5, 3'd4, 3'd2},
  localparam int IDW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int DW = $clog2(STACK_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              ackIn,
  input logic              eohIn,
  input logic              nestMode,
  input logic              intReq,
  input logic [IDW-1:0]    intVec,
  input logic              errFlag,
  input logic [PRIO_W-1:0] levelQ,
  input logic [DW-1:0]     depthQ
);
  function automatic logic [PRIO_W-1:0] prioOf(input logic [IDW-1:0] s);
    return SRC_PRIO[s*PRIO_W +: PRIO_W];
  endfunction

  a_r4_seq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (!nestMode && depthQ != '0) |-> !intReq);

  a_r5_above_level: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (prioOf(intVec) > levelQ));

  a_r7_push_level: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && intReq && !eohIn) |=>
      (levelQ == prioOf($past(intVec)) && depthQ == $past(depthQ) + DW'(1)));

  a_r8_pop_depth: assert property (@(posedge clk) disable iff (!rstN)
    (eohIn && depthQ != '0) |=> (depthQ == $past(depthQ) - DW'(1)));

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    (depthQ == DW'(STACK_DEPTH)) |-> !intReq);

  a_r10_bad_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ((ackIn && !intReq) || (eohIn && depthQ == '0)) |-> errFlag);

  a_r10_state_kept: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !intReq && !eohIn) |=> (depthQ == $past(depthQ) && $stable(levelQ)));
endmodule

bind nested_irq_ctrl nic_checker #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .STACK_DEPTH(STACK_DEPTH), .SRC_PRIO(SRC_PRIO)
) uChk (
  .clk(clk), .rstN(rstN), .ackIn(ackIn), .eohIn(eohIn), .nestMode(nestMode),
  .intReq(intReq), .intVec(intVec), .errFlag(errFlag), .levelQ(levelQ), .depthQ(depthQ)
);

// File: tb/tb_nested_irq_ctrl.sv
module tb_nested_irq_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] irqIn = '0;
  logic ackIn = 1'b0, eohIn = 1'b0, nestMode = 1'b1;
  logic intReq, errFlag;
  logic [1:0] intVec;

  logic [2:0] aIrq = '0;
  logic aAck = 1'b0, aEoh = 1'b0;
  logic aReq, aErr;
  logic [1:0] aVec;

  int nChecks = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  nested_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .ackIn(ackIn), .eohIn(eohIn),
    .nestMode(nestMode), .intReq(intReq), .intVec(intVec), .errFlag(errFlag)
  );

  // Tie and stack-full corner cases: sources 0 and 1 share priority 3, source 2 is 6
  nested_irq_ctrl #(.STACK_DEPTH(1), .SRC_PRIO({3'd6, 3'd3, 3'd3})) dutAlt (
    .clk(clk), .rstN(rstN), .irqIn(aIrq), .ackIn(aAck), .eohIn(aEoh),
    .nestMode(1'b1), .intReq(aReq), .intVec(aVec), .errFlag(aErr)
  );

  // Reference model for the default instance
  bit [2:0] mPend, mPrev;
  int mStk[3];
  int mDepth, mLevel;
  bit eReq, eErr;
  int eVec;

  function automatic int prioOf(int s);
    case (s)
      0: return 2;
      1: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic void computeExp();
    int best;
    eReq = 0; eVec = 0; best = -1;
    for (int i = 0; i < 3; i++) begin
      if (mPend[i] && mDepth < 3 && prioOf(i) > mLevel && (nestMode || mDepth == 0)
          && prioOf(i) > best) begin
        eReq = 1; eVec = i; best = prioOf(i);
      end
    end
    eErr = (ackIn && (!eReq || eohIn)) || (eohIn && mDepth == 0);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = '0; mPrev = '0; mDepth = 0; mLevel = 0;
      for (int e = 0; e < 3; e++) mStk[e] = 0;
    end else begin
      computeExp();
      if (eohIn && mDepth > 0) begin
        mDepth = mDepth - 1;
        mLevel = mStk[mDepth];
      end else if (ackIn && eReq && !eohIn) begin
        mPend[eVec] = 1'b0;
        mStk[mDepth] = mLevel;
        mDepth = mDepth + 1;
        mLevel = prioOf(eVec);
      end
      mPend = mPend | (irqIn & ~mPrev);
      mPrev = irqIn;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, then compare outputs with the model
  task automatic step(input logic [2:0] irq, input logic ack, input logic eoh,
                      input logic mode, input string tag);
    @(negedge clk);
    irqIn = irq; ackIn = ack; eohIn = eoh; nestMode = mode;
    #1;
    computeExp();
    check(intReq === eReq, {tag, " R3 R4 R5 R6 req"}, intReq, eReq);
    if (eReq) check(intVec === 2'(eVec), {tag, " R3 vec"}, intVec, eVec);
    check(errFlag === eErr, {tag, " R10 R11 err"}, errFlag, eErr);
  endtask

  task automatic hand(input bit expReq, input int expVec, input bit expErr, input string tag);
    check(intReq === expReq, {tag, " req"}, intReq, expReq);
    if (expReq) check(intVec === 2'(expVec), {tag, " vec"}, intVec, expVec);
    check(errFlag === expErr, {tag, " err"}, errFlag, expErr);
  endtask

  task automatic aStep(input logic [2:0] irq, input logic ack, input logic eoh);
    @(negedge clk);
    aIrq = irq; aAck = ack; aEoh = eoh;
    #1;
  endtask

  task automatic aHand(input bit expReq, input int expVec, input string tag);
    check(aReq === expReq, {tag, " req"}, aReq, expReq);
    if (expReq) check(aVec === 2'(expVec), {tag, " vec"}, aVec, expVec);
    check(aErr === 1'b0, {tag, " err"}, aErr, 0);
  endtask

  initial begin
    #1_000_000;
    nBad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", nChecks, 0);
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    logic [2:0] rIrq;
    void'($urandom(32'h1D5E_ED01));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    step(3'b000, 0, 0, 1, "R1"); hand(0, 0, 0, "R1 reset");
    // R10 invalid pulses while idle
    step(3'b000, 1, 0, 1, "R10"); hand(0, 0, 1, "R10 stray ack");
    step(3'b000, 0, 1, 1, "R10"); hand(0, 0, 1, "R10 stray eoh");
    step(3'b000, 0, 0, 1, "R10"); hand(0, 0, 0, "R10 state kept");
    // R2 edge latch, R7 acceptance
    step(3'b001, 0, 0, 1, "R2");
    step(3'b001, 0, 0, 1, "R2"); hand(1, 0, 0, "R2 pending src0");
    step(3'b001, 1, 0, 1, "R7");
    step(3'b001, 0, 0, 1, "R2"); hand(0, 0, 0, "R2 held line no repeat");
    // R5 preemption above level 2
    step(3'b101, 0, 0, 1, "R5");
    step(3'b101, 0, 0, 1, "R5"); hand(1, 2, 0, "R5 preempt by src2");
    step(3'b101, 1, 0, 1, "R7");
    // R6 src1 (4) waits under level 5
    step(3'b111, 0, 0, 1, "R6");
    step(3'b111, 0, 0, 1, "R6"); hand(0, 0, 0, "R6 lower waits");
    // R8 pop restores level 2, src1 now eligible
    step(3'b111, 0, 1, 1, "R8");
    step(3'b111, 0, 0, 1, "R8"); hand(1, 1, 0, "R8 level restored");
    step(3'b111, 1, 0, 1, "R7");
    step(3'b111, 0, 1, 1, "R8");
    step(3'b111, 0, 1, 1, "R8");
    step(3'b111, 0, 1, 1, "R10"); hand(0, 0, 1, "R10 surplus eoh");
    // R4 one-at-a-time mode
    step(3'b000, 0, 0, 0, "R4");
    step(3'b001, 0, 0, 0, "R4");
    step(3'b001, 0, 0, 0, "R4"); hand(1, 0, 0, "R4 first request");
    step(3'b001, 1, 0, 0, "R4");
    step(3'b111, 0, 0, 0, "R4");
    step(3'b111, 0, 0, 0, "R4"); hand(0, 0, 0, "R4 masked during handler");
    step(3'b111, 0, 0, 0, "R4"); hand(0, 0, 0, "R4 still masked");
    step(3'b111, 0, 1, 0, "R4");
    step(3'b111, 0, 0, 0, "R3"); hand(1, 2, 0, "R3 R4 highest after end");
    step(3'b111, 1, 0, 0, "R4");
    step(3'b111, 0, 1, 0, "R4");
    step(3'b111, 0, 0, 0, "R4"); hand(1, 1, 0, "R4 kept pending src1");
    step(3'b111, 1, 0, 0, "R4");
    step(3'b111, 0, 1, 0, "R4");
    // R11 ack and eoh together
    step(3'b000, 0, 0, 1, "R11");
    step(3'b001, 0, 0, 1, "R11");
    step(3'b001, 1, 0, 1, "R11");
    step(3'b101, 0, 0, 1, "R11");
    step(3'b101, 1, 1, 1, "R11"); hand(1, 2, 1, "R11 both pulses");
    step(3'b101, 0, 0, 1, "R11"); hand(1, 2, 0, "R11 ack discarded");
    step(3'b101, 1, 0, 1, "R11");
    step(3'b101, 0, 1, 1, "R11");
    step(3'b000, 0, 0, 1, "R11");

    // Random traffic against the model
    rIrq = '0;
    for (int c = 0; c < 3000; c++) begin
      logic a, e, m;
      for (int b = 0; b < 3; b++) if ($urandom % 6 == 0) rIrq[b] = ~rIrq[b];
      computeExp();
      a = (eReq && ($urandom % 3 == 0)) || ($urandom % 40 == 0);
      e = ($urandom % 7 == 0);
      m = ($urandom % 200 == 0) ? ~nestMode : nestMode;
      step(rIrq, a, e, m, "rand");
    end
    step(3'b000, 0, 0, 1, "rand");

    // Tie break and full stack on the second instance
    aStep(3'b000, 0, 0);
    aStep(3'b011, 0, 0);
    aStep(3'b011, 0, 0); aHand(1, 0, "R3 tie lowest index");
    aStep(3'b011, 1, 0);
    aStep(3'b111, 0, 0);
    aStep(3'b111, 0, 0); aHand(0, 0, "R9 stack full blocks");
    aStep(3'b111, 0, 1);
    aStep(3'b111, 0, 0); aHand(1, 2, "R3 R9 after pop");
    aStep(3'b111, 1, 0);
    aStep(3'b111, 0, 1);
    aStep(3'b111, 0, 0); aHand(1, 1, "R3 remaining tie source");
    aStep(3'b111, 1, 0);
    aStep(3'b111, 0, 1);
    aStep(3'b111, 0, 0); aHand(0, 0, "R7 all served");

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule